// File: doc/BRIEF.md
# Three-State Phase Comparator with Polarity Select

This block compares a reference pulse train with a divided-down feedback pulse train and tells an external charge pump which way to steer the loop. Both inputs are sampled on a fast sampling clock, and their rising edges are detected there. A small state machine records which input rose first. While the first edge waits for the second one, the block drives a three-level pump command: high, low, or released (high impedance). When the inputs agree, the command is released. Each high-impedance output is modelled as a value bit plus a drive-enable bit, so a pad wrapper can turn the pair into a real tri-state pin.

A polarity input swaps the roles of the two inputs, which inverts the sense of the pump command. The same core therefore suits loop filters and oscillators of either tuning slope. Two auxiliary phase-error outputs report the direction separately. One of them is a plain driven level. The other can only pull low or float, so it is exposed only as an enable. A lock flag rises after several consecutive comparisons with small error pulses. It drops as soon as one error pulse grows too wide.

The state machine has four states. IDLE means no edge is pending. PUMP_UP is entered when the steering input rose first. PUMP_DN is entered when the opposite input rose first. CLEAR lasts one cycle after both edges have been seen. Transitions: IDLE goes to PUMP_UP on a lone steering edge and to PUMP_DN on a lone opposite edge. IDLE stays in IDLE when both inputs rise in the same cycle. PUMP_UP goes to CLEAR on the opposite edge, and PUMP_DN goes to CLEAR on the steering edge. CLEAR always returns to IDLE, and edges arriving during CLEAR are ignored. The steering input is the reference when `pol_swap` is 0 and the feedback when it is 1.

Top module: `phase_det_tri`

## Requirements
- R1: After reset, `pump_oe`, `err_ref`, `err_fb_oe` and `locked` are all 0.
- R2: With `pol_swap`=0 and the reference rising first, the outputs are `pump_oe`=1, `pump_val`=1, `err_ref`=0 and `err_fb_oe`=1 (pull low). They appear on the second clock edge after the reference rise and hold until the feedback edge has been handled.
- R3: With `pol_swap`=0 and the feedback rising first, the outputs are `pump_oe`=1, `pump_val`=0, `err_ref`=1 and `err_fb_oe`=0 (floating).
- R4: When no comparison is pending, the outputs are `pump_oe`=0, `err_ref`=0 and `err_fb_oe`=0, at either polarity. Inputs that rise in the same sampling cycle count as equal phase and produce no pump pulse.
- R5: With `pol_swap`=1 the roles are exchanged. A leading reference gives the R3 output set, and a leading feedback gives the R2 output set.
- R6: The pump is still driven one clock edge after the second input edge has been sampled. It is released on the next edge (the one-cycle CLEAR state) and never changes directly from up to down.
- R7: `locked` rises when a comparison completes whose error pulse was shorter than LOCK_TOL cycles (default 4), provided it is the LOCK_PERIODS-th such comparison in a row (default 4).
- R8: `locked` falls in the cycle in which a pump pulse reaches LOCK_TOL cycles, while that pulse is still active. The run of good comparisons then starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference pulse train |
| fb_in | input | 1 | Divided feedback pulse train |
| pol_swap | input | 1 | 1 exchanges the roles of reference and feedback |
| pump_val | output | 1 | Pump command level, meaningful when pump_oe is 1 |
| pump_oe | output | 1 | Pump drive enable; 0 is the high-impedance state |
| err_ref | output | 1 | Driven phase-error flag, high while the pump is driven low |
| err_fb_oe | output | 1 | Pull-low enable of the open-drain phase-error output |
| locked | output | 1 | Lock indicator |

## Verification
The comparator is exercised with four input patterns: reference leading, reference lagging, both inputs rising in the same cycle, and a lead that stays too long. The first three are run at both polarity settings. Leading against lagging shows the direction decoding of all four pump and error outputs. Repeating those runs with the polarity swapped shows that the swap inverts the sense of the pump command. The simultaneous-rise case separates true equality from a one-cycle pulse, and it is checked on every cycle. The over-long lead separates a slow loss of lock from an immediate one, and the good comparisons that follow show that the lock count restarts.

// File: rtl/pd_pkg.sv
package pd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PUMP_UP = 2'd1,
        ST_PUMP_DN = 2'd2,
        ST_CLEAR   = 2'd3
    } pd_state_t;

    typedef struct packed {
        logic pump_val;
        logic pump_oe;
        logic err_ref;
        logic err_fb_oe;
    } pd_out_t;

endpackage

// File: rtl/pd_edge_sampler.sv
module pd_edge_sampler #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh[0] <= 1'b0;
        else        sh[0] <= din;
    end

    genvar gi;
    generate
        for (gi = 1; gi <= STAGES; gi++) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh[gi] <= 1'b0;
                else        sh[gi] <= sh[gi-1];
            end
        end
    endgenerate

    // rising edge seen at the last sampled stage
    assign rise = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
    import pd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    swap,
    input  logic    ref_rise,
    input  logic    fb_rise,
    output pd_out_t outs,
    output logic    cmp_done,
    output logic    pulse_on
);

    pd_state_t state, state_nx;
    logic      up_rise, dn_rise;

    // the steering input pushes the pump up
    assign up_rise = swap ? fb_rise  : ref_rise;
    assign dn_rise = swap ? ref_rise : fb_rise;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (up_rise && !dn_rise)      state_nx = ST_PUMP_UP;
                else if (dn_rise && !up_rise) state_nx = ST_PUMP_DN;
            end
            ST_PUMP_UP: if (dn_rise) state_nx = ST_CLEAR;
            ST_PUMP_DN: if (up_rise) state_nx = ST_CLEAR;
            ST_CLEAR:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        outs = '0;
        unique case (state)
            ST_PUMP_UP: begin
                outs.pump_val  = 1'b1;
                outs.pump_oe   = 1'b1;
                outs.err_fb_oe = 1'b1;
            end
            ST_PUMP_DN: begin
                outs.pump_oe = 1'b1;
                outs.err_ref = 1'b1;
            end
            ST_IDLE, ST_CLEAR: outs = '0;
        endcase
    end

    assign pulse_on = (state == ST_PUMP_UP) || (state == ST_PUMP_DN);
    assign cmp_done = (state == ST_CLEAR) ||
                      ((state == ST_IDLE) && up_rise && dn_rise);

endmodule

// File: rtl/pd_lock.sv
module pd_lock #(
    parameter int LOCK_TOL     = 4,
    parameter int LOCK_PERIODS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_on,
    input  logic cmp_done,
    output logic locked
);

    localparam int WW = $clog2(LOCK_TOL + 1);
    localparam int GW = $clog2(LOCK_PERIODS + 1);
    localparam logic [WW-1:0] TOL_V  = WW'(LOCK_TOL);
    localparam logic [WW-1:0] TOL_M1 = WW'(LOCK_TOL - 1);
    localparam logic [GW-1:0] PER_V  = GW'(LOCK_PERIODS);
    localparam logic [GW-1:0] PER_M1 = GW'(LOCK_PERIODS - 1);

    logic [WW-1:0] width;
    logic [GW-1:0] good;
    logic          bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width  <= '0;
            good   <= '0;
            bad    <= 1'b0;
            locked <= 1'b0;
        end else if (pulse_on) begin
            if (width != TOL_V) width <= width + 1'b1;
            if (width == TOL_M1) begin
                bad    <= 1'b1;
                locked <= 1'b0;
                good   <= '0;
            end
        end else if (cmp_done) begin
            width <= '0;
            bad   <= 1'b0;
            if (!bad) begin
                if (good == PER_M1) locked <= 1'b1;
                if (good != PER_V)  good   <= good + 1'b1;
            end
        end
    end

endmodule

// File: rtl/phase_det_tri.sv
module phase_det_tri
    import pd_pkg::*;
#(
    parameter int SYNC_STAGES  = 1,
    parameter int LOCK_TOL     = 4,
    parameter int LOCK_PERIODS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    input  logic pol_swap,
    output logic pump_val,
    output logic pump_oe,
    output logic err_ref,
    output logic err_fb_oe,
    output logic locked
);

    logic    ref_rise, fb_rise, cmp_done, pulse_on;
    pd_out_t outs;

    pd_edge_sampler #(.STAGES(SYNC_STAGES)) u_ref (
        .clk(clk), .rst_n(rst_n), .din(ref_in), .rise(ref_rise));

    pd_edge_sampler #(.STAGES(SYNC_STAGES)) u_fb (
        .clk(clk), .rst_n(rst_n), .din(fb_in), .rise(fb_rise));

    pd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .swap(pol_swap),
        .ref_rise(ref_rise), .fb_rise(fb_rise),
        .outs(outs), .cmp_done(cmp_done), .pulse_on(pulse_on));

    pd_lock #(.LOCK_TOL(LOCK_TOL), .LOCK_PERIODS(LOCK_PERIODS)) u_lock (
        .clk(clk), .rst_n(rst_n), .pulse_on(pulse_on),
        .cmp_done(cmp_done), .locked(locked));

    assign pump_val  = outs.pump_val;
    assign pump_oe   = outs.pump_oe;
    assign err_ref   = outs.err_ref;
    assign err_fb_oe = outs.err_fb_oe;

endmodule

// File: rtl/pd_checks.sv
module pd_checks (
    input logic clk,
    input logic rst_n,
    input logic pump_val,
    input logic pump_oe,
    input logic err_ref,
    input logic err_fb_oe,
    input logic locked
);

    a_r2_up_pulls_fb: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_oe && pump_val) |-> (err_fb_oe && !err_ref));

    a_r3_dn_drives_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_oe && !pump_val) |-> (err_ref && !err_fb_oe));

    a_r4_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !pump_oe |-> (!err_ref && !err_fb_oe));

    a_r6_no_direct_reversal: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_oe && pump_val) |=> !(pump_oe && !pump_val));

    a_r7_lock_rises_released: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> !pump_oe);

endmodule

bind phase_det_tri pd_checks u_pd_checks (
    .clk(clk), .rst_n(rst_n), .pump_val(pump_val), .pump_oe(pump_oe),
    .err_ref(err_ref), .err_fb_oe(err_fb_oe), .locked(locked));

// File: tb/tb_phase_det_tri.sv
`timescale 1ns/1ps
module tb_phase_det_tri;

    localparam int TOL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0, fb_in = 1'b0, pol_swap = 1'b0;
    logic pump_val, pump_oe, err_ref, err_fb_oe, locked;
    int   n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    phase_det_tri dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .pol_swap(pol_swap), .pump_val(pump_val), .pump_oe(pump_oe),
        .err_ref(err_ref), .err_fb_oe(err_fb_oe), .locked(locked));

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // {pump_oe, pump_val, err_ref, err_fb_oe}
    function automatic logic [3:0] outs();
        return {pump_oe, pump_val, err_ref, err_fb_oe};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    // one comparison: first input rises, second follows 3 cycles later
    task automatic run_lead(input string tag, input logic swap, input logic ref_first);
        logic up;
        logic [3:0] exp_mid;
        pol_swap = swap;
        up = ref_first ^ swap;
        exp_mid = up ? 4'b1101 : 4'b1010;
        if (ref_first) ref_in = 1'b1; else fb_in = 1'b1;
        tick(3);
        check({tag, " driven"}, outs(), exp_mid);
        ref_in = 1'b1; fb_in = 1'b1;
        tick(1);
        check("R6 still driven one edge after second rise", outs(), exp_mid);
        tick(1);
        check("R6 released after clear", outs(), 4'b0000);
        ref_in = 1'b0; fb_in = 1'b0;
        tick(2);
    endtask

    task automatic run_equal(input logic swap);
        pol_swap = swap;
        ref_in = 1'b1; fb_in = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            check("R4 simultaneous rise gives no pulse", outs(), 4'b0000);
        end
        ref_in = 1'b0; fb_in = 1'b0;
        tick(2);
    endtask

    task automatic run_lock();
        do_reset();
        pol_swap = 1'b0;
        for (int i = 0; i < 3; i++) run_lead("R2 lock run", 1'b0, 1'b1);
        check("R7 not locked after three", {3'b0, locked}, 4'b0000);
        run_lead("R2 lock run", 1'b0, 1'b1);
        check("R7 locked after four", {3'b0, locked}, 4'b0001);
        ref_in = 1'b1;
        tick(TOL + 3);
        check("R8 lock drops mid pulse", {3'b0, locked}, 4'b0000);
        check("R8 pulse still active", {3'b0, pump_oe}, 4'b0001);
        fb_in = 1'b1;
        tick(3);
        ref_in = 1'b0; fb_in = 1'b0;
        tick(2);
        for (int i = 0; i < 3; i++) run_lead("R3 relock run", 1'b0, 1'b0);
        check("R8 count restarted", {3'b0, locked}, 4'b0000);
        run_lead("R3 relock run", 1'b0, 1'b0);
        check("R7 relocked", {3'b0, locked}, 4'b0001);
    endtask

    initial begin
        do_reset();
        check("R1 reset outputs", outs(), 4'b0000);
        check("R1 reset lock", {3'b0, locked}, 4'b0000);
        run_lead("R2 ref leads swap0", 1'b0, 1'b1);
        run_lead("R3 ref lags swap0", 1'b0, 1'b0);
        run_lead("R5 ref leads swap1", 1'b1, 1'b1);
        run_lead("R5 ref lags swap1", 1'b1, 1'b0);
        run_equal(1'b0);
        run_equal(1'b1);
        run_lock();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule